// File: doc/BRIEF.md
# Two-Digit Multiplexed Seven-Segment Driver

This block drives a two-digit seven-segment display. Both digits share one set of seven segment lines, and one select output decides which digit is lit. It takes two 4-bit values, each a hexadecimal digit from 0 to F. A free-running divider on the 100 MHz system clock alternates between the two digits fast enough that both appear lit together. The segment lines always carry the pattern of the digit that the select line picks.

The divider does not make a second clock. It makes a one-cycle enable pulse, so every register stays on the system clock. The pulse period is set by the parameter `TICK_LAST`. The default of 49999 flips the select every 50,000 cycles, which is 2,000 flips per second at 100 MHz. A simulation can set a small value instead.

Top module: `segmux_top`

## Requirements
- R1: While `rst` is high at a clock edge, the refresh count returns to zero and `digitSel` becomes 0 at that edge. `segOut` then shows the pattern of `rightDigit`.
- R2: After reset is released, `digitSel` inverts on the (`TICK_LAST`+1)-th rising edge. From then on it inverts once every `TICK_LAST`+1 edges and holds its value in between.
- R3: When `digitSel` is 1, `segOut` is the pattern of `leftDigit`. When `digitSel` is 0, it is the pattern of `rightDigit`. The digit value used is the one sampled at the same edge that set `digitSel`.
- R4: `segOut` is active-high, with segment A on bit 6 down to segment G on bit 0. The patterns for the decimal digits are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1110011.
- R5: The hexadecimal letter values use the same bit order. Their patterns are: A=1110111, b=0011111, C=1001110, d=0111101, E=1001111, F=1000111.
- R6: A change of either digit input shows on `segOut` one edge later, even at the edge where `digitSel` flips. No cycle ever shows one digit's pattern while `digitSel` points at the other digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| leftDigit | input | 4 | Hex value for the left digit |
| rightDigit | input | 4 | Hex value for the right digit |
| segOut | output | 7 | Segment lines A (bit 6) to G (bit 0), 1 = lit |
| digitSel | output | 1 | 1 = left digit lit, 0 = right digit lit |

## Verification
The bench goes after the edge where the select line flips while the digit inputs change in the same cycle. A design that registered the segments from the old select value would show one digit's pattern on the other digit for a cycle. It also sweeps all sixteen values through both digit positions, so a wrong table entry or a reversed bit order gives a wrong pattern at once. It counts the exact spacing of flips after a reset released in mid-stream, because an off-by-one terminal compare shifts every flip by one cycle. It also checks that a reset issued while the left digit is lit forces the right digit back on the next edge.

// File: rtl/segmux_pkg.sv
package segmux_pkg;

  typedef logic [3:0] hexDigit_t;
  typedef logic [6:0] segPat_t;

  // Strobes from the refresh control to the display datapath
  typedef struct packed {
    logic clear;  // synchronous reset request
    logic flip;   // invert the digit select this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/segmux_decode.sv
module segmux_decode
  import segmux_pkg::*;
(
  input  hexDigit_t nibble,
  output segPat_t   pattern
);

  // Segment A on bit 6 down to G on bit 0, active-high
  always_comb begin
    case (nibble)
      4'h0: pattern = 7'b1111110;
      4'h1: pattern = 7'b0110000;
      4'h2: pattern = 7'b1101101;
      4'h3: pattern = 7'b1111001;
      4'h4: pattern = 7'b0110011;
      4'h5: pattern = 7'b1011011;
      4'h6: pattern = 7'b1011111;
      4'h7: pattern = 7'b1110000;
      4'h8: pattern = 7'b1111111;
      4'h9: pattern = 7'b1110011;
      4'hA: pattern = 7'b1110111;
      4'hB: pattern = 7'b0011111;
      4'hC: pattern = 7'b1001110;
      4'hD: pattern = 7'b0111101;
      4'hE: pattern = 7'b1001111;
      default: pattern = 7'b1000111;
    endcase
  end

endmodule

// File: rtl/segmux_ctrl.sv
module segmux_ctrl
  import segmux_pkg::*;
#(
  parameter int TICK_LAST = 49999
) (
  input  logic        clk,
  input  logic        rst,
  output ctrlStrobe_t strb
);

  localparam int CNT_W = (TICK_LAST < 1) ? 1 : $clog2(TICK_LAST + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TICK_LAST);

  logic [CNT_W-1:0] countQ;
  logic             atLast;

  assign atLast = (countQ == LAST_C);

  always_ff @(posedge clk) begin
    if (rst)         countQ <= '0;
    else if (atLast) countQ <= '0;
    else             countQ <= countQ + 1'b1;
  end

  assign strb.clear = rst;
  assign strb.flip  = atLast & ~rst;

  // R2: the count never passes its terminal value
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    countQ <= LAST_C);

  // R2: a flip strobe restarts the count
  assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (rst)
    strb.flip |=> (countQ == '0));

  // R1: reset brings the count back to zero
  assert_reset_count_R1: assert property (@(posedge clk)
    rst |=> (countQ == '0));

endmodule

// File: rtl/segmux_dpath.sv
module segmux_dpath
  import segmux_pkg::*;
(
  input  logic        clk,
  input  ctrlStrobe_t strb,
  input  hexDigit_t   leftDigit,
  input  hexDigit_t   rightDigit,
  output segPat_t     segOut,
  output logic        digitSel
);

  logic      selQ;
  logic      selNext;
  hexDigit_t chosen;
  segPat_t   patNext;
  segPat_t   segQ;

  // Next select is known before the edge, so segments follow it exactly
  always_comb begin
    if (strb.clear)     selNext = 1'b0;
    else if (strb.flip) selNext = ~selQ;
    else                selNext = selQ;
  end

  assign chosen = selNext ? leftDigit : rightDigit;

  segmux_decode uDecode (
    .nibble  (chosen),
    .pattern (patNext)
  );

  always_ff @(posedge clk) begin
    selQ <= selNext;
    segQ <= patNext;
  end

  assign digitSel = selQ;
  assign segOut   = segQ;

  // R1: reset drives the right digit
  assert_reset_right_R1: assert property (@(posedge clk)
    strb.clear |=> !digitSel);

  // R2: a flip strobe inverts the select
  assert_flip_toggles_R2: assert property (@(posedge clk) disable iff (strb.clear)
    strb.flip |=> (digitSel != $past(digitSel)));

  // R2: without a flip the select holds
  assert_sel_holds_R2: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.flip |=> $stable(digitSel));

  // R6: every hex pattern lights at least one segment
  assert_seg_lit_R6: assert property (@(posedge clk) disable iff (strb.clear)
    1'b1 |=> (segOut != '0));

endmodule

// File: rtl/segmux_top.sv
module segmux_top
  import segmux_pkg::*;
#(
  parameter int TICK_LAST = 49999
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] leftDigit,
  input  logic [3:0] rightDigit,
  output logic [6:0] segOut,
  output logic       digitSel
);

  ctrlStrobe_t strb;

  segmux_ctrl #(.TICK_LAST(TICK_LAST)) uCtrl (
    .clk  (clk),
    .rst  (rst),
    .strb (strb)
  );

  segmux_dpath uDpath (
    .clk        (clk),
    .strb       (strb),
    .leftDigit  (leftDigit),
    .rightDigit (rightDigit),
    .segOut     (segOut),
    .digitSel   (digitSel)
  );

endmodule

// File: tb/tb_segmux_top.sv
`timescale 1ns/1ps
module tb_segmux_top;

  localparam int LAST = 4;

  typedef struct {
    logic       sel;
    logic [6:0] seg;
    string      selTag;
    string      segTag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] leftDigit = 4'h3;
  logic [3:0] rightDigit = 4'h7;
  logic [6:0] segOut;
  logic       digitSel;

  int testsRun = 0;
  int testsFail = 0;
  int cycles = 0;
  bit done = 1'b0;

  expItem_t expQ[$];

  int  mCnt = 0;
  bit  mSel = 1'b0;

  always #2 clk = ~clk;

  segmux_top #(.TICK_LAST(LAST)) dut (
    .clk        (clk),
    .rst        (rst),
    .leftDigit  (leftDigit),
    .rightDigit (rightDigit),
    .segOut     (segOut),
    .digitSel   (digitSel)
  );

  // Segment patterns from R4 (decimal) and R5 (letters)
  function automatic logic [6:0] refPat(input logic [3:0] d);
    case (d)
      4'h0: return 7'b1111110;
      4'h1: return 7'b0110000;
      4'h2: return 7'b1101101;
      4'h3: return 7'b1111001;
      4'h4: return 7'b0110011;
      4'h5: return 7'b1011011;
      4'h6: return 7'b1011111;
      4'h7: return 7'b1110000;
      4'h8: return 7'b1111111;
      4'h9: return 7'b1110011;
      4'hA: return 7'b1110111;
      4'hB: return 7'b0011111;
      4'hC: return 7'b1001110;
      4'hD: return 7'b0111101;
      4'hE: return 7'b1001111;
      default: return 7'b1000111;
    endcase
  endfunction

  // Driver: inputs are set at the falling edge; predict state after next rise
  task automatic step(input string tag);
    expItem_t it;
    logic [3:0] shown;
    if (rst) begin
      mCnt = 0; mSel = 1'b0;
    end else if (mCnt == LAST) begin
      mCnt = 0; mSel = ~mSel;
    end else begin
      mCnt++;
    end
    shown  = mSel ? leftDigit : rightDigit;
    it.sel = mSel;
    it.seg = refPat(shown);
    if (tag != "") begin
      it.selTag = tag; it.segTag = tag;
    end else if (rst) begin
      it.selTag = "R1"; it.segTag = "R1";
    end else begin
      it.selTag = "R2";
      it.segTag = (shown < 4'hA) ? "R3/R4" : "R3/R5";
    end
    expQ.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    cycles++;
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      testsRun++;
      if (digitSel !== e.sel) begin
        testsFail++;
        $display("FAIL %s digitSel actual=%0b expected=%0b", e.selTag, digitSel, e.sel);
      end
      testsRun++;
      if (segOut !== e.seg) begin
        testsFail++;
        $display("FAIL %s segOut actual=%b expected=%b", e.segTag, segOut, e.seg);
      end
    end
  end

  // Watchdog
  initial begin
    wait (cycles > 100000 || done);
    if (!done) begin
      testsRun++; testsFail++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state with right digit 7
    for (int i = 0; i < 3; i++) step("R1");
    rst = 1'b0;
    // R2/R3: steady digits across several flips
    leftDigit = 4'h3; rightDigit = 4'h8;
    for (int i = 0; i < 30; i++) step("");
    // R4/R5: sweep every value through both positions
    for (int r = 0; r < 3; r++) begin
      for (int v = 0; v < 16; v++) begin
        rightDigit = 4'(v);
        leftDigit  = 4'(15 - v);
        step("");
      end
    end
    // R6: digits change every cycle, including at flip edges
    for (int i = 0; i < 60; i++) begin
      leftDigit  = 4'($urandom_range(0, 15));
      rightDigit = 4'($urandom_range(0, 15));
      step((mCnt == LAST) ? "R6" : "");
    end
    // R1: reset while the left digit is lit
    while (!(mSel == 1'b1 && mCnt == 1)) step("");
    rst = 1'b1;
    leftDigit = 4'h1; rightDigit = 4'hE;
    step("R1");
    step("R1");
    rst = 1'b0;
    // R2: flip spacing after a mid-stream reset release
    for (int i = 0; i < 25; i++) step("");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule